// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns bytes handed to a one-entry holding buffer into asynchronous serial frames on a single line. An external baud generator supplies a one-clock pulse for each bit period. Every line transition happens on the clock edge that sees this pulse. The frame shape is set at run time: parity off, odd or even; data order low bit first or high bit first; one or two stop bits. A two-bit mode selects one of four operating styles. These are plain framing, idle-line multiprocessor, address-bit multiprocessor, and auto-baud (break plus sync).

Software can arm two sticky marks before it writes a byte. An address mark makes the next byte an address frame. In address-bit mode this sets an extra frame bit. In idle-line mode it puts a long mark gap in front of the frame. A break mark makes the next write emit a long low break and a one-bit mark delimiter. In auto-baud mode the byte written with a break mark is then sent as a normal frame, usually the 0x55 sync character. In the other modes that byte is a dummy and is not sent. A ready flag shows when the buffer can take a byte. A complete flag shows when the line has gone idle with nothing left to send. A synchronous hold input keeps the whole block in its idle state.

Top module: `uart_frame_tx`

## Requirements
- R1: After `rst_ni` goes low, and on every cycle while `soft_rst_i` is high, the outputs are `tx_o`=1, `buf_rdy_o`=1, `tx_done_o`=0, `addr_pend_o`=0 and `brk_pend_o`=0. Writes and mark strobes presented while held are ignored, so no frame follows release.
- R2: A frame starts on the first bit tick after an accepted write. It is a low start bit, then 8 data bits, then a high stop bit. Each bit lasts from one tick to the next. With `msb_first_i`=0 the data go out bit 0 first.
- R3: With `msb_first_i`=1 the data bits go out bit 7 first.
- R4: With `par_en_i`=1 a parity bit follows the data. With `par_even_i`=1 it makes the number of ones across data and parity even. With `par_even_i`=0 it makes that number odd.
- R5: With `two_stop_i`=1 the frame ends with two high stop bits instead of one.
- R6: Mode encoding on `mode_i` is 0 plain, 1 idle-line, 2 address-bit, 3 auto-baud. In mode 2 each frame carries one extra bit after the data and parity and before the stops. That bit is 1 for an address-marked byte and 0 otherwise. In mode 0 an address mark adds no bit.
- R7: In mode 1, an address-marked frame is preceded by `IDLE_BITS` (default 11) high bit periods, counted from its launch tick. An unmarked frame starts at once.
- R8: A break-marked write drives the line low for `BRK_BITS` (default 13) bit periods, then high for one delimiter period. Outside mode 3 no character follows, and the complete flag rises one tick after the delimiter.
- R9: In mode 3 a break-marked write is followed, right after the delimiter, by a normal frame that carries the written byte.
- R10: `addr_mark_i` and `break_mark_i` set `addr_pend_o` and `brk_pend_o`. These marks attach to the next accepted write. They stay visible until that byte's launch tick and are cleared on it.
- R11: `buf_rdy_o` falls on an accepted write and rises on the tick that launches the byte. A write while `buf_rdy_o`=0 is dropped.
- R12: `tx_done_o` rises on the tick that ends the last stop bit when no byte is waiting. Any accepted write clears it. A byte written during a frame starts on the tick that ends the current frame, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous hold in idle state |
| bit_tick_i | input | 1 | One-clock pulse per bit period |
| par_en_i | input | 1 | Parity enable |
| par_even_i | input | 1 | 1 even parity, 0 odd parity |
| msb_first_i | input | 1 | 1 sends data bit 7 first |
| two_stop_i | input | 1 | 1 selects two stop bits |
| mode_i | input | 2 | 0 plain, 1 idle-line, 2 address-bit, 3 auto-baud |
| addr_mark_i | input | 1 | Strobe: mark next byte as address |
| break_mark_i | input | 1 | Strobe: next write sends a break |
| wr_i | input | 1 | Buffer write strobe |
| wr_data_i | input | DATA_W | Byte to send |
| tx_o | output | 1 | Serial line, idle high |
| buf_rdy_o | output | 1 | Buffer can take a byte |
| tx_done_o | output | 1 | Line idle and buffer empty |
| addr_pend_o | output | 1 | Address mark armed |
| brk_pend_o | output | 1 | Break mark armed |

## Verification
The bench uses the default parameters: 8 data bits, an 11-period idle gap and a 13-period break. It raises the bit tick for one clock every other clock, so each bit period is two clocks. This keeps a full break, delimiter and sync frame, or a gap plus a frame, short enough to walk bit by bit. Each expected bit string comes from a model built from the requirements. The model covers both data orders, both parity senses, both stop lengths and the address bit. The bench sends back-to-back frames to reach the launch-at-frame-end path, and it drops a write while the buffer is full.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN     = 2'd0,
    MODE_IDLE_LINE = 2'd1,
    MODE_ADDR_BIT  = 2'd2,
    MODE_AUTO_BAUD = 2'd3
  } tx_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_BREAK,
    ST_DELIM,
    ST_SHIFT
  } tx_state_e;
endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              addr_mark_i,
  input  logic              break_mark_i,
  input  logic              take_i,
  output logic              wr_accept_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              addr_o,
  output logic              brk_o,
  output logic              addr_pend_o,
  output logic              brk_pend_o
);
  logic full_q, addr_q, brk_q, apend_q, bpend_q;
  logic [DATA_W-1:0] data_q;

  assign wr_accept_o = wr_i && !full_q && !soft_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0; addr_q <= 1'b0; brk_q <= 1'b0;
      apend_q <= 1'b0; bpend_q <= 1'b0; data_q <= '0;
    end else if (soft_rst_i) begin
      full_q <= 1'b0; addr_q <= 1'b0; brk_q <= 1'b0;
      apend_q <= 1'b0; bpend_q <= 1'b0;
    end else begin
      if (addr_mark_i)  apend_q <= 1'b1;
      if (break_mark_i) bpend_q <= 1'b1;
      if (wr_accept_o) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
        addr_q <= apend_q || addr_mark_i;
        brk_q  <= bpend_q || break_mark_i;
      end
      // marks belong to the byte being launched
      if (take_i) begin
        full_q  <= 1'b0;
        apend_q <= 1'b0;
        bpend_q <= 1'b0;
      end
    end
  end

  assign full_o      = full_q;
  assign data_o      = data_q;
  assign addr_o      = addr_q;
  assign brk_o       = brk_q;
  assign addr_pend_o = apend_q;
  assign brk_pend_o  = bpend_q;
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned FRAME_W = DATA_W + 5,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               par_en_i,
  input  logic               par_even_i,
  input  logic               msb_first_i,
  input  logic               two_stop_i,
  input  logic               abit_en_i,
  input  logic               abit_i,
  output logic [FRAME_W-1:0] bits_o,
  output logic [LEN_W-1:0]   len_o
);
  int unsigned pos;

  always_comb begin
    bits_o    = '1;
    bits_o[0] = 1'b0;
    for (int unsigned i = 0; i < DATA_W; i++)
      bits_o[1+i] = msb_first_i ? data_i[DATA_W-1-i] : data_i[i];
    pos = DATA_W + 1;
    if (par_en_i) begin
      bits_o[pos] = par_even_i ? ^data_i : ~^data_i;
      pos = pos + 1;
    end
    if (abit_en_i) begin
      bits_o[pos] = abit_i;
      pos = pos + 1;
    end
    // stop bits are the ones left in place
    len_o = LEN_W'(pos + 1 + (two_stop_i ? 1 : 0));
  end
endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDLE_BITS = 11,
  parameter int unsigned BRK_BITS  = 13,
  parameter int unsigned FRAME_W   = DATA_W + 5,
  parameter int unsigned LEN_W     = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               soft_rst_i,
  input  logic               bit_tick_i,
  input  tx_mode_e           mode_i,
  input  logic               wr_accept_i,
  input  logic               buf_full_i,
  input  logic [DATA_W-1:0]  buf_data_i,
  input  logic               buf_addr_i,
  input  logic               buf_brk_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic [LEN_W-1:0]   frame_len_i,
  output logic               take_o,
  output logic [DATA_W-1:0]  fr_char_o,
  output logic               fr_abit_o,
  output logic               tx_o,
  output logic               done_o
);
  localparam int unsigned MAX_A = (IDLE_BITS > BRK_BITS) ? IDLE_BITS : BRK_BITS;
  localparam int unsigned MAX_C = (MAX_A > FRAME_W) ? MAX_A : FRAME_W;
  localparam int unsigned CNT_W = $clog2(MAX_C + 1);

  tx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               tx_q, tx_d, done_q, done_d, addr_q, addr_d;
  logic [DATA_W-1:0]  char_q, char_d;
  logic               frame_end, launch, enter_shift;

  assign frame_end = bit_tick_i &&
                     ((st_q == ST_SHIFT && cnt_q == '0) ||
                      (st_q == ST_DELIM && mode_i != MODE_AUTO_BAUD));
  assign launch    = buf_full_i && ((bit_tick_i && st_q == ST_IDLE) || frame_end);
  assign take_o    = launch;
  assign fr_char_o = launch ? buf_data_i : char_q;
  assign fr_abit_o = launch ? buf_addr_i : addr_q;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; tx_d = tx_q;
    done_d = done_q; char_d = char_q; addr_d = addr_q;
    enter_shift = 1'b0;
    if (bit_tick_i) begin
      case (st_q)
        ST_GAP:   if (cnt_q == '0) enter_shift = 1'b1; else cnt_d = cnt_q - 1'b1;
        ST_BREAK: if (cnt_q == '0) begin st_d = ST_DELIM; tx_d = 1'b1; end
                  else cnt_d = cnt_q - 1'b1;
        ST_DELIM: if (mode_i == MODE_AUTO_BAUD) enter_shift = 1'b1;
        ST_SHIFT: if (cnt_q != '0) begin
                    tx_d  = sh_q[0];
                    sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
                    cnt_d = cnt_q - 1'b1;
                  end
        default: ;
      endcase
    end
    if (frame_end && !buf_full_i) begin
      st_d = ST_IDLE; tx_d = 1'b1; done_d = 1'b1;
    end
    if (launch) begin
      char_d = buf_data_i;
      addr_d = buf_addr_i;
      if (buf_brk_i) begin
        st_d = ST_BREAK; tx_d = 1'b0; cnt_d = CNT_W'(BRK_BITS - 1);
      end else if (mode_i == MODE_IDLE_LINE && buf_addr_i) begin
        st_d = ST_GAP; tx_d = 1'b1; cnt_d = CNT_W'(IDLE_BITS - 1);
      end else begin
        enter_shift = 1'b1;
      end
    end
    if (enter_shift) begin
      st_d  = ST_SHIFT;
      tx_d  = frame_bits_i[0];
      sh_d  = {1'b1, frame_bits_i[FRAME_W-1:1]};
      cnt_d = CNT_W'(frame_len_i - 1'b1);
    end
    if (wr_accept_i) done_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '1; tx_q <= 1'b1;
      done_q <= 1'b0; char_q <= '0; addr_q <= 1'b0;
    end else if (soft_rst_i) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '1; tx_q <= 1'b1;
      done_q <= 1'b0; addr_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; tx_q <= tx_d;
      done_q <= done_d; char_q <= char_d; addr_q <= addr_d;
    end
  end

  assign tx_o   = tx_q;
  assign done_o = done_q;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned IDLE_BITS = 11,
  parameter int unsigned BRK_BITS  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              bit_tick_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              msb_first_i,
  input  logic              two_stop_i,
  input  logic [1:0]        mode_i,
  input  logic              addr_mark_i,
  input  logic              break_mark_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              tx_o,
  output logic              buf_rdy_o,
  output logic              tx_done_o,
  output logic              addr_pend_o,
  output logic              brk_pend_o
);
  localparam int unsigned FRAME_W = DATA_W + 5;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  tx_mode_e           mode;
  logic               wr_accept, take, buf_full, buf_addr, buf_brk, fr_abit;
  logic [DATA_W-1:0]  buf_data, fr_char;
  logic [FRAME_W-1:0] fr_bits;
  logic [LEN_W-1:0]   fr_len;

  assign mode = tx_mode_e'(mode_i);

  uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .soft_rst_i, .wr_i, .wr_data_i, .addr_mark_i, .break_mark_i,
    .take_i(take), .wr_accept_o(wr_accept), .full_o(buf_full), .data_o(buf_data),
    .addr_o(buf_addr), .brk_o(buf_brk), .addr_pend_o, .brk_pend_o
  );

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .data_i(fr_char), .par_en_i, .par_even_i, .msb_first_i, .two_stop_i,
    .abit_en_i(mode == MODE_ADDR_BIT), .abit_i(fr_abit),
    .bits_o(fr_bits), .len_o(fr_len)
  );

  uart_tx_seq #(
    .DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS), .BRK_BITS(BRK_BITS),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk_i, .rst_ni, .soft_rst_i, .bit_tick_i, .mode_i(mode),
    .wr_accept_i(wr_accept), .buf_full_i(buf_full), .buf_data_i(buf_data),
    .buf_addr_i(buf_addr), .buf_brk_i(buf_brk), .frame_bits_i(fr_bits),
    .frame_len_i(fr_len), .take_o(take), .fr_char_o(fr_char), .fr_abit_o(fr_abit),
    .tx_o, .done_o(tx_done_o)
  );

  assign buf_rdy_o = !buf_full;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              bit_tick_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              tx_o,
  input logic              buf_rdy_o,
  input logic              tx_done_o,
  input logic              addr_pend_o,
  input logic              brk_pend_o
);
  p_hold_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (tx_o && buf_rdy_o && !tx_done_o && !addr_pend_o && !brk_pend_o));

  p_tick_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !soft_rst_i) |=> $stable(tx_o));

  p_write_fills_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && buf_rdy_o && !soft_rst_i) |=> !buf_rdy_o);

  p_write_clears_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && buf_rdy_o && !soft_rst_i) |=> !tx_done_o);

  p_done_line_high_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> tx_o);

  p_mark_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(addr_pend_o) || $fell(brk_pend_o)) |-> $past(bit_tick_i || soft_rst_i));

  p_data_known_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && buf_rdy_o) |-> !$isunknown(wr_data_i));
endmodule

bind uart_frame_tx uart_frame_tx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BRK_N = 13;
  localparam int GAP_N = 11;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, tick = 1'b0;
  logic par_en = 1'b0, par_even = 1'b0, msb = 1'b0, two_stop = 1'b0;
  logic [1:0] mode = 2'd0;
  logic amark = 1'b0, bmark = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic tx, rdy, done, apend, bpend;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .bit_tick_i(tick),
    .par_en_i(par_en), .par_even_i(par_even), .msb_first_i(msb), .two_stop_i(two_stop),
    .mode_i(mode), .addr_mark_i(amark), .break_mark_i(bmark), .wr_i(wr),
    .wr_data_i(wdata), .tx_o(tx), .buf_rdy_o(rdy), .tx_done_o(done),
    .addr_pend_o(apend), .brk_pend_o(bpend)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(output logic b);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    b = tx;
  endtask

  task automatic write_byte(logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic pulse_addr();
    @(negedge clk) amark = 1'b1;
    @(negedge clk) amark = 1'b0;
  endtask

  task automatic pulse_brk();
    @(negedge clk) bmark = 1'b1;
    @(negedge clk) bmark = 1'b0;
  endtask

  function automatic void model(input logic [7:0] d, input bit ab,
                                output logic [15:0] eb, output int len);
    int idx, ones;
    eb = '1; eb[0] = 1'b0; idx = 1; ones = 0;
    for (int i = 0; i < 8; i++) begin
      eb[idx] = msb ? d[7-i] : d[i];
      if (d[i]) ones++;
      idx++;
    end
    if (par_en) begin
      eb[idx] = par_even ? ((ones % 2) == 1) : ((ones % 2) == 0);
      idx++;
    end
    if (mode == 2'd2) begin eb[idx] = ab; idx++; end
    len = idx + 1 + (two_stop ? 1 : 0);
  endfunction

  // steps through gap + frame (byte already written) and the trailing idle tick
  task automatic run_frame(string req, logic [7:0] d, bit ab, int gap);
    logic [15:0] eb; int len, bad; logic b;
    model(d, ab, eb, len);
    bad = 0;
    for (int k = 0; k < gap; k++) begin step(b); if (b !== 1'b1) bad++; end
    for (int k = 0; k < len; k++) begin step(b); if (b !== eb[k]) bad++; end
    check({req, " bit mismatches"}, bad, 0);
    step(b);
    check({req, " line idle after stop"}, int'(b), 1);
    check({req, " complete flag"}, int'(done), 1);
  endtask

  task automatic t_reset();
    check("R1 reset tx", int'(tx), 1);
    check("R1 reset ready", int'(rdy), 1);
    check("R1 reset done", int'(done), 0);
    check("R1 reset marks", int'({apend, bpend}), 0);
  endtask

  task automatic t_basic();
    write_byte(8'hA5); run_frame("R2 8N1 A5", 8'hA5, 0, 0);
    write_byte(8'h01); run_frame("R2 8N1 01", 8'h01, 0, 0);
  endtask

  task automatic t_msb();
    msb = 1'b1;
    write_byte(8'h35); run_frame("R3 msb first 35", 8'h35, 0, 0);
    msb = 1'b0;
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_even = 1'b1;
    write_byte(8'h07); run_frame("R4 even 07", 8'h07, 0, 0);
    write_byte(8'h03); run_frame("R4 even 03", 8'h03, 0, 0);
    par_even = 1'b0;
    write_byte(8'h07); run_frame("R4 odd 07", 8'h07, 0, 0);
    par_en = 1'b0;
  endtask

  task automatic t_stop();
    two_stop = 1'b1; par_en = 1'b1; par_even = 1'b1;
    write_byte(8'h5A); run_frame("R5 two stops", 8'h5A, 0, 0);
    two_stop = 1'b0; par_en = 1'b0;
  endtask

  task automatic t_addr_bit();
    mode = 2'd2;
    pulse_addr();
    check("R10 addr mark armed", int'(apend), 1);
    write_byte(8'h42);
    check("R10 addr mark held until launch", int'(apend), 1);
    run_frame("R6 address frame", 8'h42, 1, 0);
    check("R10 addr mark cleared", int'(apend), 0);
    write_byte(8'h42); run_frame("R6 data frame", 8'h42, 0, 0);
    mode = 2'd0;
    pulse_addr(); write_byte(8'h42);
    run_frame("R6 plain mode ignores mark", 8'h42, 0, 0);
  endtask

  task automatic t_idle_line();
    mode = 2'd1;
    pulse_addr(); write_byte(8'hC8);
    run_frame("R7 gap before address", 8'hC8, 0, GAP_N);
    write_byte(8'hC8);
    run_frame("R7 no gap for data", 8'hC8, 0, 0);
    mode = 2'd0;
  endtask

  task automatic t_break();
    int bad; logic b;
    pulse_brk();
    check("R10 break mark armed", int'(bpend), 1);
    write_byte(8'h00);
    bad = 0;
    for (int k = 0; k < BRK_N; k++) begin step(b); if (b !== 1'b0) bad++; end
    check("R8 break low periods", bad, 0);
    check("R10 break mark cleared", int'(bpend), 0);
    step(b);
    check("R8 delimiter high", int'(b), 1);
    check("R8 not complete at delimiter", int'(done), 0);
    step(b);
    check("R8 no character after break", int'(b), 1);
    check("R8 complete after delimiter", int'(done), 1);
  endtask

  task automatic t_auto_baud();
    int bad; logic b;
    mode = 2'd3;
    pulse_brk(); write_byte(8'h55);
    bad = 0;
    for (int k = 0; k < BRK_N; k++) begin step(b); if (b !== 1'b0) bad++; end
    step(b); if (b !== 1'b1) bad++;
    check("R9 break and delimiter", bad, 0);
    run_frame("R9 sync frame", 8'h55, 0, 0);
    mode = 2'd0;
  endtask

  task automatic t_full_drop();
    logic b;
    write_byte(8'h3C);
    check("R11 ready low after write", int'(rdy), 0);
    write_byte(8'hC3);
    run_frame("R11 first byte kept", 8'h3C, 0, 0);
    step(b);
    check("R11 dropped byte not sent", int'(b), 1);
    check("R11 ready after launch", int'(rdy), 1);
  endtask

  task automatic t_back_to_back();
    logic [15:0] ea, eb2; int la, lb, bad; logic b;
    model(8'h11, 0, ea, la);
    model(8'hE2, 0, eb2, lb);
    write_byte(8'h11);
    check("R12 write clears complete", int'(done), 0);
    bad = 0;
    step(b); if (b !== ea[0]) bad++;
    check("R11 ready at launch", int'(rdy), 1);
    write_byte(8'hE2);
    for (int k = 1; k < la; k++) begin step(b); if (b !== ea[k]) bad++; end
    for (int k = 0; k < lb; k++) begin
      step(b); if (b !== eb2[k]) bad++;
      if (k == 0) check("R12 no complete between frames", int'(done), 0);
    end
    check("R12 back-to-back bits", bad, 0);
    step(b);
    check("R12 complete after second", int'(done), 1);
  endtask

  task automatic t_soft_reset();
    int bad; logic b;
    write_byte(8'h0F);
    step(b); step(b); step(b);
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk);
    check("R1 hold tx", int'(tx), 1);
    check("R1 hold ready", int'(rdy), 1);
    check("R1 hold done", int'(done), 0);
    write_byte(8'h99); pulse_addr(); pulse_brk();
    check("R1 marks ignored while held", int'({apend, bpend}), 0);
    @(negedge clk) soft_rst = 1'b0;
    bad = 0;
    for (int k = 0; k < 12; k++) begin step(b); if (b !== 1'b1) bad++; end
    check("R1 no frame after release", bad, 0);
    check("R1 ready after release", int'(rdy), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_msb();
    t_parity();
    t_stop();
    t_addr_bit();
    t_idle_line();
    t_break();
    t_auto_baud();
    t_full_drop();
    t_back_to_back();
    t_soft_reset();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule